// File: doc/BRIEF.md
# Interrupt Output Pin Controller

This block gathers a set of latched interrupt request flags and turns them into drive values for one primary interrupt pin and one optional secondary pin. Each flag is set by a one-cycle pulse from its source and cleared by a write-one-to-clear strobe. A per-flag enable decides whether a pending flag counts toward a pin. A flag that is disabled stays latched, and it counts again as soon as its enable returns.

Each pin runs its own small state machine with three states: `PIN_IDLE` (inactive), `PIN_ACTIVE` (asserted) and `PIN_GAP` (forced inactive for a timed gap). The transitions are:

- idle-to-active: some enabled flag of the pin's group is pending.
- active-to-idle: no enabled flag of the group is pending.
- active-to-gap: in edge mode only, a pending flag was cleared while others remain.
- gap-to-active or gap-to-idle: the gap counter ran out, or the pin left edge mode. The pending state at that moment picks the target.

In level mode the pin acts as an open-drain, active-low output. In edge mode it is always driven, and a polarity bit picks the active level. The gap lets an external edge-triggered receiver see a fresh edge while other requests are still pending.

A routing control moves the eight general-purpose-input flags (bits 8 to 15) off the primary pin and onto the secondary pin. The secondary pin uses the same mode, polarity and gap settings as the primary pin.

Top module: `irq_pin_ctrl`

## Requirements
- R1: A set pulse latches its flag, and a clear strobe on a flag without a set pulse in the same cycle clears it. If set and clear arrive in the same cycle, the flag ends up set.
- R2: A flag whose enable is low has no effect on either pin, and it keeps its latched value while disabled.
- R3: In level mode (edge control 0), a pin's output enable is 1 and its drive value is 0 while any enabled flag of its group is pending. Otherwise the output enable is 0. The output follows the flags with two clock cycles of latency: one to latch and one to update the state.
- R4: In level mode the polarity control has no effect: the drive value is always 0.
- R5: In edge mode (edge control 1), the output enable is always 1. The drive value equals the polarity control (1 means active high) when the pin is active, and its inverse otherwise.
- R6: In edge mode, a set pulse on an enabled flag while none of the group's flags is pending makes the pin active two cycles later.
- R7: In edge mode, clearing a pending flag while another enabled flag of the same group stays pending makes the pin inactive for a gap and then active again.
- R8: The gap width in clock cycles is 128, 64, 32 or 16 for gap select codes 00, 01, 10 and 11.
- R9: In edge mode, clearing the last pending flag makes the pin inactive with no return to active.
- R10: A new request that arrives during a gap does not shorten it. The pin becomes active when the full gap ends.
- R11: When the route control is 1 and the secondary select is 2'b10, flags 8 to 15 drive only the secondary pin, with the shared mode, polarity and gap width.
- R12: Otherwise the secondary pin's output enable and drive value are 0, and flags 8 to 15 count toward the primary pin.
- R13: After reset, all flags are clear and both pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set_i | input | 16 | One-cycle set pulses, one per flag |
| req_clr_i | input | 16 | Write-one-to-clear strobes, one per flag |
| req_en_i | input | 16 | Per-flag enables |
| edge_mode_i | input | 1 | 0 selects level mode, 1 selects edge mode |
| active_high_i | input | 1 | Edge-mode active level (1 = high) |
| gap_sel_i | input | 2 | Gap width select code |
| gpi_route_i | input | 1 | Moves flags 8 to 15 to the secondary pin |
| sec_sel_i | input | 2 | Secondary pin function select; 2'b10 enables the interrupt role |
| pri_drive_o | output | 1 | Primary pin drive value |
| pri_oe_o | output | 1 | Primary pin output enable |
| sec_drive_o | output | 1 | Secondary pin drive value |
| sec_oe_o | output | 1 | Secondary pin output enable |

## Verification
A flag latched wrongly, or a state machine stuck in the wrong state, shows up on the pin within two cycles of the stimulus, because every path from a strobe to a pin passes through exactly two registers. A gap counter loaded with the wrong value, or one that stops early, shows up only at the end of the gap, so the bench counts every inactive cycle of each gap and compares the total with the width for that code. Routing faults appear as activity on the wrong pin right after a general-purpose-input request. A long random level-mode run compares both pins each cycle against a bench model of the flags.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    typedef enum logic [1:0] {
        PIN_IDLE   = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_GAP    = 2'd2
    } pin_state_e;

    localparam int PIN_PRI = 0;
    localparam int PIN_SEC = 1;
    localparam int NUM_PINS = 2;

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int NUM_REQ  = 16,
    parameter int GPI_BASE = 8,
    parameter int GPI_CNT  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] set_i,
    input  logic [NUM_REQ-1:0] clr_i,
    input  logic [NUM_REQ-1:0] en_i,
    input  logic               route_eff_i,
    output logic [1:0]         pend_o,
    output logic [1:0]         clr_evt_o
);

    function automatic logic [NUM_REQ-1:0] gpi_mask_f();
        logic [NUM_REQ-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (i >= GPI_BASE && i < GPI_BASE + GPI_CNT) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NUM_REQ-1:0] GPI_MASK = gpi_mask_f();

    logic [NUM_REQ-1:0] flag_q;
    logic [NUM_REQ-1:0] live;
    logic [NUM_REQ-1:0] hit;
    logic [NUM_REQ-1:0] sec_mask;
    logic [NUM_REQ-1:0] pri_mask;
    logic [1:0]         evt_q;

    assign sec_mask = route_eff_i ? GPI_MASK : '0;
    assign pri_mask = ~sec_mask;
    assign live     = flag_q & en_i;
    // enabled pending flags removed by a strobe this cycle
    assign hit      = live & clr_i & ~set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            evt_q  <= '0;
        end else begin
            flag_q <= set_i | (flag_q & ~clr_i);
            evt_q  <= {|(hit & sec_mask), |(hit & pri_mask)};
        end
    end

    assign pend_o    = {|(live & sec_mask), |(live & pri_mask)};
    assign clr_evt_o = evt_q;

    // R1: a set pulse always leaves its flag latched
    p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R1: a clear strobe without a set pulse leaves the flag cleared
    p_clear_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(clr_i) & ~$past(set_i)) == '0));

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pin_pkg::*;
#(
    parameter int GAP_W0 = 128,
    parameter int GAP_W1 = 64,
    parameter int GAP_W2 = 32,
    parameter int GAP_W3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_mode_i,
    input  logic       pend_i,
    input  logic       clr_evt_i,
    input  logic [1:0] gap_sel_i,
    output logic       active_o
);

    localparam int GAP_M01 = (GAP_W0 > GAP_W1) ? GAP_W0 : GAP_W1;
    localparam int GAP_M23 = (GAP_W2 > GAP_W3) ? GAP_W2 : GAP_W3;
    localparam int GAP_MAX = (GAP_M01 > GAP_M23) ? GAP_M01 : GAP_M23;
    localparam int CW      = $clog2(GAP_MAX + 1);

    pin_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    function automatic logic [CW-1:0] gap_load_f(input logic [1:0] sel);
        logic [CW-1:0] v;
        unique case (sel)
            2'b00: v = CW'(GAP_W0 - 1);
            2'b01: v = CW'(GAP_W1 - 1);
            2'b10: v = CW'(GAP_W2 - 1);
            default: v = CW'(GAP_W3 - 1);
        endcase
        return v;
    endfunction

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (pend_i) state_d = PIN_ACTIVE;
            end
            PIN_ACTIVE: begin
                if (!pend_i) begin
                    state_d = PIN_IDLE;
                end else if (edge_mode_i && clr_evt_i) begin
                    state_d = PIN_GAP;
                    cnt_d   = gap_load_f(gap_sel_i);
                end
            end
            PIN_GAP: begin
                if (!edge_mode_i || cnt_q == '0) begin
                    state_d = pend_i ? PIN_ACTIVE : PIN_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = PIN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active_o = (state_q == PIN_ACTIVE);
    end

    // R7: a gap is only entered from the active state while in edge mode
    p_gap_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_GAP && $past(state_q) != PIN_GAP)
        |-> ($past(state_q) == PIN_ACTIVE && $past(edge_mode_i)));

    // R8: the gap counter stays below the longest programmed width
    p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_GAP) |-> (int'(cnt_q) < GAP_MAX));

    // R3: level mode held for two cycles never shows a gap
    p_level_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && $past(!edge_mode_i)) |-> (state_q != PIN_GAP));

endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive (
    input  logic active_i,
    input  logic edge_mode_i,
    input  logic active_high_i,
    input  logic pin_en_i,
    output logic drive_o,
    output logic oe_o
);

    always_comb begin
        if (!pin_en_i) begin
            drive_o = 1'b0;
            oe_o    = 1'b0;
        end else if (!edge_mode_i) begin
            drive_o = 1'b0;
            oe_o    = active_i;
        end else begin
            drive_o = active_i ? active_high_i : ~active_high_i;
            oe_o    = 1'b1;
        end
    end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int NUM_REQ  = 16,
    parameter int GPI_BASE = 8,
    parameter int GPI_CNT  = 8,
    parameter int GAP_W0   = 128,
    parameter int GAP_W1   = 64,
    parameter int GAP_W2   = 32,
    parameter int GAP_W3   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_set_i,
    input  logic [NUM_REQ-1:0] req_clr_i,
    input  logic [NUM_REQ-1:0] req_en_i,
    input  logic               edge_mode_i,
    input  logic               active_high_i,
    input  logic [1:0]         gap_sel_i,
    input  logic               gpi_route_i,
    input  logic [1:0]         sec_sel_i,
    output logic               pri_drive_o,
    output logic               pri_oe_o,
    output logic               sec_drive_o,
    output logic               sec_oe_o
);

    localparam logic [1:0] SEC_IRQ_SEL = 2'b10;

    logic                route_eff;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] clr_evt;
    logic [NUM_PINS-1:0] pin_en;
    logic [NUM_PINS-1:0] active;
    logic [NUM_PINS-1:0] drive;
    logic [NUM_PINS-1:0] oe;

    assign route_eff = gpi_route_i && (sec_sel_i == SEC_IRQ_SEL);
    assign pin_en    = {route_eff, 1'b1};

    irq_req_bank #(
        .NUM_REQ  (NUM_REQ),
        .GPI_BASE (GPI_BASE),
        .GPI_CNT  (GPI_CNT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (req_set_i),
        .clr_i       (req_clr_i),
        .en_i        (req_en_i),
        .route_eff_i (route_eff),
        .pend_o      (pend),
        .clr_evt_o   (clr_evt)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irq_pin_fsm #(
            .GAP_W0 (GAP_W0),
            .GAP_W1 (GAP_W1),
            .GAP_W2 (GAP_W2),
            .GAP_W3 (GAP_W3)
        ) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .edge_mode_i (edge_mode_i),
            .pend_i      (pend[g]),
            .clr_evt_i   (clr_evt[g]),
            .gap_sel_i   (gap_sel_i),
            .active_o    (active[g])
        );

        irq_pad_drive u_pad (
            .active_i      (active[g]),
            .edge_mode_i   (edge_mode_i),
            .active_high_i (active_high_i),
            .pin_en_i      (pin_en[g]),
            .drive_o       (drive[g]),
            .oe_o          (oe[g])
        );
    end

    assign pri_drive_o = drive[PIN_PRI];
    assign pri_oe_o    = oe[PIN_PRI];
    assign sec_drive_o = drive[PIN_SEC];
    assign sec_oe_o    = oe[PIN_SEC];

    // R4: level mode never drives the pin high, whatever the polarity
    p_level_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i |-> (!pri_drive_o && !sec_drive_o));

    // R12: secondary pin is released unless its interrupt role is selected
    p_sec_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpi_route_i && sec_sel_i == 2'b10) |-> (!sec_oe_o && !sec_drive_o));

    // R5: edge mode always enables the primary driver
    p_edge_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode_i |-> pri_oe_o);

endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_set, req_clr, req_en;
    logic        edge_mode, active_high, gpi_route;
    logic [1:0]  gap_sel, sec_sel;
    logic        pri_drive, pri_oe, sec_drive, sec_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_pin_ctrl i_irq_pin_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_set_i     (req_set),
        .req_clr_i     (req_clr),
        .req_en_i      (req_en),
        .edge_mode_i   (edge_mode),
        .active_high_i (active_high),
        .gap_sel_i     (gap_sel),
        .gpi_route_i   (gpi_route),
        .sec_sel_i     (sec_sel),
        .pri_drive_o   (pri_drive),
        .pri_oe_o      (pri_oe),
        .sec_drive_o   (sec_drive),
        .sec_oe_o      (sec_oe)
    );

    // expected {drive, oe} for a pin
    function automatic logic [1:0] exp_pin(bit act, bit edg, bit pol, bit pen);
        if (!pen) return 2'b00;
        if (!edg) return {1'b0, act};
        return {act ? pol : ~pol, 1'b1};
    endfunction

    function automatic int gap_width(logic [1:0] code);
        case (code)
            2'b00: return 128;
            2'b01: return 64;
            2'b10: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic bit sec_on();
        return gpi_route && (sec_sel == 2'b10);
    endfunction

    function automatic logic [1:0] got_pin(int pin);
        return (pin == 0) ? {pri_drive, pri_oe} : {sec_drive, sec_oe};
    endfunction

    function automatic bit pin_active(int pin);
        return got_pin(pin) == exp_pin(1'b1, edge_mode, active_high,
                                       (pin == 0) ? 1'b1 : sec_on());
    endfunction

    task automatic check_pin(input string tag, input int pin, input bit act);
        logic [1:0] exp;
        exp = exp_pin(act, edge_mode, active_high, (pin == 0) ? 1'b1 : sec_on());
        n_chk++;
        if (got_pin(pin) !== exp) begin
            n_fail++;
            $display("FAIL %s pin%0d {drive,oe} got %b expected %b",
                     tag, pin, got_pin(pin), exp);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_set(input logic [15:0] m);
        req_set = m;
        tick();
        req_set = '0;
    endtask

    task automatic pulse_clr(input logic [15:0] m);
        req_clr = m;
        tick();
        req_clr = '0;
    endtask

    task automatic measure_gap(input int pin, output int n);
        n = 0;
        while (!pin_active(pin) && n < 400) begin
            n++;
            tick();
        end
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w;
        logic [15:0] mf;
        bit pp, ps;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        req_set = '0; req_clr = '0; req_en = '1;
        edge_mode = 0; active_high = 0; gap_sel = 2'b00;
        gpi_route = 0; sec_sel = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        check_pin("R13 reset pri", 0, 0);
        check_pin("R13 reset sec", 1, 0);

        // level mode basics
        pulse_set(16'h0001); tick();
        check_pin("R3 level active", 0, 1);
        req_set = 16'h0008; req_clr = 16'h0009; tick();
        req_set = '0; req_clr = '0; tick();
        check_pin("R1 set wins over clear", 0, 1);
        pulse_clr(16'h0008); tick();
        check_pin("R1 clear releases", 0, 0);

        active_high = 1;
        pulse_set(16'h0004); tick();
        check_pin("R4 level ignores polarity", 0, 1);
        pulse_clr(16'h0004); tick();
        check_pin("R3 level released", 0, 0);
        active_high = 0;

        req_en = ~16'h0010;
        pulse_set(16'h0010); tick(); tick();
        check_pin("R2 disabled flag ignored", 0, 0);
        req_en = '1; tick();
        check_pin("R2 flag kept while disabled", 0, 1);
        pulse_clr(16'h0010); tick();
        check_pin("R2 cleared", 0, 0);

        // edge mode
        edge_mode = 1; tick();
        check_pin("R5 edge idle level", 0, 0);
        pulse_set(16'h0001); tick();
        check_pin("R6 edge new request", 0, 1);
        active_high = 1; #1;
        check_pin("R5 polarity high", 0, 1);

        for (int code = 0; code < 4; code++) begin
            gap_sel = code[1:0];
            pulse_set(16'h0002); tick();
            pulse_clr(16'h0002); tick();
            measure_gap(0, w);
            check_int($sformatf("R8 gap width code %0d", code), w, gap_width(code[1:0]));
            check_pin("R7 active after gap", 0, 1);
        end

        gap_sel = 2'b11;
        pulse_set(16'h0002); tick();
        pulse_clr(16'h0002); tick();
        check_pin("R10 gap start", 0, 0);
        for (int i = 1; i < 16; i++) begin
            req_set = (i == 4) ? 16'h0020 : 16'h0000;
            tick();
            req_set = '0;
            check_pin("R10 gap not shortened", 0, 0);
        end
        tick();
        check_pin("R10 active at gap end", 0, 1);

        pulse_clr(16'h0021); tick();
        check_pin("R9 last cleared inactive", 0, 0);
        repeat (200) tick();
        check_pin("R9 no return", 0, 0);

        // routing
        gpi_route = 1; sec_sel = 2'b10; tick();
        check_pin("R11 sec idle", 1, 0);
        pulse_set(16'h0200); tick();
        check_pin("R11 sec active", 1, 1);
        check_pin("R11 pri untouched", 0, 0);
        pulse_set(16'h0400); tick();
        pulse_clr(16'h0200); tick();
        measure_gap(1, w);
        check_int("R11 sec shares gap width", w, 16);
        check_pin("R11 sec active after gap", 1, 1);

        edge_mode = 0; sec_sel = 2'b01; tick(); tick();
        check_pin("R12 sec released", 1, 0);
        check_pin("R12 gpi on primary", 0, 1);
        pulse_clr(16'h0400); tick();
        check_pin("R12 primary released", 0, 0);

        // random level-mode run against a model of the flags
        req_en = 16'($urandom);
        gpi_route = 1'($urandom);
        sec_sel = ($urandom % 2) ? 2'b10 : 2'b01;
        mf = '0; pp = 0; ps = 0;
        for (int c = 0; c < 150; c++) begin
            logic [15:0] s, k;
            logic [15:0] smask;
            s = 16'($urandom) & 16'($urandom) & 16'($urandom);
            k = 16'($urandom) & 16'($urandom);
            req_set = s; req_clr = k;
            @(posedge clk);
            mf = s | (mf & ~k);
            #1;
            req_set = '0; req_clr = '0;
            check_pin("R3 random level pri", 0, pp);
            check_pin("R1 random level sec", 1, ps);
            smask = sec_on() ? 16'hFF00 : 16'h0000;
            pp = |(mf & req_en & ~smask);
            ps = |(mf & req_en & smask);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule